// File: doc/BRIEF.md
# Vector Arithmetic Engine

This block is a small vector execution engine. It keeps a bank of eight vector registers, and each register holds 64 integer elements of 64 bits. A command port takes one vector instruction at a time. The engine then walks through the element indices one per clock. For each index it reads both source elements in the same cycle and pushes them into a four-stage arithmetic pipeline that can take a new element every clock. Results are written back into the destination register as they leave the pipeline. A single-cycle done pulse marks the end of the instruction.

There are four operations: vector plus vector, scalar plus vector, vector times vector and scalar times vector. All arithmetic wraps at 64 bits. A host port writes single elements while the engine is idle, and a debug port reads any element at any time. Elements of one instruction do not depend on each other, so the engine does no hazard checking between them. It also has no loop overhead between elements.

Top module: `vec_engine`

## Requirements
- R1: After a synchronous active-high reset, `cmd_ready` is 1 and `done` is 0, and no element write takes place until a command or host write arrives.
- R2: `cmd_op` encoding: 0 sets vd[i] = va[i] + vb[i], 1 sets vd[i] = scalar + vb[i], 2 sets vd[i] = va[i] * vb[i], 3 sets vd[i] = scalar * vb[i]. Additions wrap modulo 2^64.
- R3: Multiplication keeps only the low 64 bits of the 128-bit product.
- R4: In the two scalar forms (op 1 and 3), every element takes `cmd_scalar` in place of the va operand, and the contents of register `cmd_srca` have no effect.
- R5: One accepted command rewrites all 64 elements of register `cmd_dst` and leaves every other register unchanged.
- R6: `cmd_ready` falls in the cycle after a command is accepted (`cmd_valid` and `cmd_ready` both 1 at a clock edge). It stays 0 until the last element has been written back. A command offered while `cmd_ready` is 0 is ignored.
- R7: `done` is high for exactly one cycle, 69 cycles after the acceptance cycle (64 elements + 4 pipeline stages + 1). `cmd_ready` returns to 1 in that same cycle.
- R8: The destination may be the same register as either source or both, and the result still equals the operation applied to the old source contents.
- R9: While `cmd_ready` is 1, `host_we` writes `host_data` into element `host_idx` of register `host_reg` at the clock edge. While `cmd_ready` is 0, host writes are ignored.
- R10: `dbg_data` shows element `dbg_idx` of register `dbg_reg` combinationally, with no clock delay.
- R11: A new command offered in the cycle where `done` is high is accepted at once, and it completes with the same 69-cycle timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and able to accept a command |
| cmd_op | input | 2 | Operation code (see R2) |
| cmd_dst | input | 3 | Destination register |
| cmd_srca | input | 3 | First source register (vector forms only) |
| cmd_srcb | input | 3 | Second source register |
| cmd_scalar | input | 64 | Scalar operand for ops 1 and 3 |
| done | output | 1 | One-cycle pulse after the final write-back |
| host_we | input | 1 | Host element write enable |
| host_reg | input | 3 | Host write register |
| host_idx | input | 6 | Host write element index |
| host_data | input | 64 | Host write data |
| dbg_reg | input | 3 | Debug read register |
| dbg_idx | input | 6 | Debug read element index |
| dbg_data | output | 64 | Debug read data |

## Verification
Faults in the element counter or in the pipeline valid chain first show up as a change in timing. The done pulse moves away from its fixed 69-cycle point, and `cmd_ready` comes back early or late, so one instruction is enough to expose them. Faults in the operand select, the operation decode or the write-back address do not change timing. They only show up as wrong or misplaced elements. For that reason the bench compares the whole register bank through the debug port after every instruction. A stale-operand fault appears only when the destination is also a source, and that case has its own tests.

// File: rtl/vec_pkg.sv
package vec_pkg;

    localparam int NUM_VREG = 8;
    localparam int VLEN     = 64;
    localparam int EW       = 64;
    localparam int PIPE_LAT = 4;

    localparam int RW = $clog2(NUM_VREG);
    localparam int IW = $clog2(VLEN);
    localparam int AW = RW + IW;

    typedef logic [RW-1:0] vreg_t;
    typedef logic [IW-1:0] idx_t;
    typedef logic [EW-1:0] elem_t;

    // bit 1 selects multiply, bit 0 selects the scalar operand form
    typedef enum logic [1:0] {
        OP_ADD_VV = 2'd0,
        OP_ADD_SV = 2'd1,
        OP_MUL_VV = 2'd2,
        OP_MUL_SV = 2'd3
    } vop_e;

    typedef struct packed {
        logic  valid;
        logic  last;
        vop_e  op;
        vreg_t dst;
        idx_t  idx;
        elem_t a;
        elem_t b;
    } issue_t;

    typedef struct packed {
        logic  valid;
        logic  last;
        vreg_t dst;
        idx_t  idx;
        elem_t res;
    } result_t;

    function automatic logic op_is_scalar(vop_e op);
        return op[0];
    endfunction

    function automatic logic op_is_mul(vop_e op);
        return op[1];
    endfunction

    function automatic elem_t alu_eval(vop_e op, elem_t a, elem_t b);
        elem_t r;
        if (op_is_mul(op)) r = a * b;   // low EW bits of the product
        else               r = a + b;
        return r;
    endfunction

endpackage

// File: rtl/vec_rf.sv
module vec_rf
    import vec_pkg::*;
(
    input  logic  clk,
    input  vreg_t ra_reg,
    input  idx_t  ra_idx,
    output elem_t ra_data,
    input  vreg_t rb_reg,
    input  idx_t  rb_idx,
    output elem_t rb_data,
    input  vreg_t rd_reg,
    input  idx_t  rd_idx,
    output elem_t rd_data,
    input  logic  we,
    input  vreg_t w_reg,
    input  idx_t  w_idx,
    input  elem_t w_data
);

    localparam int DEPTH = NUM_VREG * VLEN;

    elem_t mem [DEPTH];

    logic [AW-1:0] addr_a, addr_b, addr_d, addr_w;

    assign addr_a = {ra_reg, ra_idx};
    assign addr_b = {rb_reg, rb_idx};
    assign addr_d = {rd_reg, rd_idx};
    assign addr_w = {w_reg, w_idx};

    // two operand ports and one debug port, all asynchronous
    assign ra_data = mem[addr_a];
    assign rb_data = mem[addr_b];
    assign rd_data = mem[addr_d];

    always_ff @(posedge clk) begin
        if (we) mem[addr_w] <= w_data;
    end

endmodule

// File: rtl/vec_pipe.sv
module vec_pipe
    import vec_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  issue_t  in_op,
    output result_t out_res
);

    localparam int NRES = PIPE_LAT - 1;

    issue_t  s1;
    result_t rs [NRES];

    // stage 1: operand capture
    always_ff @(posedge clk) begin
        if (rst) begin
            s1.valid <= 1'b0;
        end else begin
            s1 <= in_op;
        end
    end

    // stage 2: arithmetic
    always_ff @(posedge clk) begin
        if (rst) begin
            rs[0].valid <= 1'b0;
        end else begin
            rs[0].valid <= s1.valid;
            rs[0].last  <= s1.last;
            rs[0].dst   <= s1.dst;
            rs[0].idx   <= s1.idx;
            rs[0].res   <= alu_eval(s1.op, s1.a, s1.b);
        end
    end

    // remaining stages: result transport
    generate
        for (genvar g = 1; g < NRES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    rs[g].valid <= 1'b0;
                end else begin
                    rs[g] <= rs[g-1];
                end
            end
        end
    endgenerate

    assign out_res = rs[NRES-1];

    AST_OUT_IDX_ORDER: assert property (@(posedge clk) disable iff (rst)
        (out_res.valid && !out_res.last) |=> (out_res.valid && out_res.idx == $past(out_res.idx) + 1'b1)); // R5

    AST_OUT_SAME_DST: assert property (@(posedge clk) disable iff (rst)
        (out_res.valid && !out_res.last) |=> (out_res.dst == $past(out_res.dst))); // R5

endmodule

// File: rtl/vec_seq.sv
module vec_seq
    import vec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [1:0]  cmd_op,
    input  vreg_t       cmd_dst,
    input  vreg_t       cmd_srca,
    input  vreg_t       cmd_srcb,
    input  elem_t       cmd_scalar,
    output vreg_t       rd_reg_a,
    output vreg_t       rd_reg_b,
    output idx_t        rd_idx,
    input  elem_t       rd_data_a,
    input  elem_t       rd_data_b,
    output issue_t      issue,
    input  logic        wb_valid,
    input  logic        wb_last,
    output logic        done
);

    localparam idx_t IDX_LAST = idx_t'(VLEN - 1);

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_DRAIN} seq_state_e;

    seq_state_e state;
    idx_t       idx;
    vop_e       cur_op;
    vreg_t      cur_dst, cur_a, cur_b;
    elem_t      cur_scalar;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        cur_op     <= vop_e'(cmd_op);
                        cur_dst    <= cmd_dst;
                        cur_a      <= cmd_srca;
                        cur_b      <= cmd_srcb;
                        cur_scalar <= cmd_scalar;
                        idx        <= '0;
                        state      <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    idx <= idx + 1'b1;
                    if (idx == IDX_LAST) state <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (wb_valid && wb_last) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cmd_ready = (state == ST_IDLE);
    assign rd_reg_a  = cur_a;
    assign rd_reg_b  = cur_b;
    assign rd_idx    = idx;

    always_comb begin
        issue.valid = (state == ST_ISSUE);
        issue.last  = (idx == IDX_LAST);
        issue.op    = cur_op;
        issue.dst   = cur_dst;
        issue.idx   = idx;
        issue.a     = op_is_scalar(cur_op) ? cur_scalar : rd_data_a;
        issue.b     = rd_data_b;
    end

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready); // R6

    AST_WB_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> !cmd_ready); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(wb_valid && wb_last) && cmd_ready)); // R7

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ISSUE && idx != IDX_LAST) |=> (state == ST_ISSUE && idx == $past(idx) + 1'b1)); // R5

endmodule

// File: rtl/vec_engine.sv
module vec_engine
    import vec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [RW-1:0]     cmd_dst,
    input  logic [RW-1:0]     cmd_srca,
    input  logic [RW-1:0]     cmd_srcb,
    input  logic [EW-1:0]     cmd_scalar,
    output logic              done,
    input  logic              host_we,
    input  logic [RW-1:0]     host_reg,
    input  logic [IW-1:0]     host_idx,
    input  logic [EW-1:0]     host_data,
    input  logic [RW-1:0]     dbg_reg,
    input  logic [IW-1:0]     dbg_idx,
    output logic [EW-1:0]     dbg_data
);

    vreg_t   rd_reg_a, rd_reg_b;
    idx_t    rd_idx;
    elem_t   rd_data_a, rd_data_b;
    issue_t  issue;
    result_t wb;

    logic    host_ok;
    logic    w_en;
    vreg_t   w_reg;
    idx_t    w_idx;
    elem_t   w_data;

    vec_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_op     (cmd_op),
        .cmd_dst    (cmd_dst),
        .cmd_srca   (cmd_srca),
        .cmd_srcb   (cmd_srcb),
        .cmd_scalar (cmd_scalar),
        .rd_reg_a   (rd_reg_a),
        .rd_reg_b   (rd_reg_b),
        .rd_idx     (rd_idx),
        .rd_data_a  (rd_data_a),
        .rd_data_b  (rd_data_b),
        .issue      (issue),
        .wb_valid   (wb.valid),
        .wb_last    (wb.last),
        .done       (done)
    );

    vec_pipe u_pipe (
        .clk     (clk),
        .rst     (rst),
        .in_op   (issue),
        .out_res (wb)
    );

    // write port: pipeline results while busy, host data only while idle
    assign host_ok = host_we && cmd_ready;
    assign w_en    = wb.valid || host_ok;
    assign w_reg   = wb.valid ? wb.dst : host_reg;
    assign w_idx   = wb.valid ? wb.idx : host_idx;
    assign w_data  = wb.valid ? wb.res : host_data;

    vec_rf u_rf (
        .clk     (clk),
        .ra_reg  (rd_reg_a),
        .ra_idx  (rd_idx),
        .ra_data (rd_data_a),
        .rb_reg  (rd_reg_b),
        .rb_idx  (rd_idx),
        .rb_data (rd_data_b),
        .rd_reg  (dbg_reg),
        .rd_idx  (dbg_idx),
        .rd_data (dbg_data),
        .we      (w_en),
        .w_reg   (w_reg),
        .w_idx   (w_idx),
        .w_data  (w_data)
    );

    AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (rst)
        !(wb.valid && host_ok)); // R9

    AST_NO_ISSUE_IDLE: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !issue.valid); // R6

endmodule

// File: tb/vec_engine_tb_top.sv
module vec_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NR = 8;
    localparam int NE = 64;
    localparam int EXP_TURN = NE + 4 + 1;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [1:0]  cmd_op;
    logic [2:0]  cmd_dst, cmd_srca, cmd_srcb;
    logic [63:0] cmd_scalar;
    logic        done;
    logic        host_we;
    logic [2:0]  host_reg;
    logic [5:0]  host_idx;
    logic [63:0] host_data;
    logic [2:0]  dbg_reg;
    logic [5:0]  dbg_idx;
    logic [63:0] dbg_data;

    logic [63:0] model [NR][NE];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_engine dut_i (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_dst(cmd_dst), .cmd_srca(cmd_srca), .cmd_srcb(cmd_srcb),
        .cmd_scalar(cmd_scalar), .done(done),
        .host_we(host_we), .host_reg(host_reg), .host_idx(host_idx), .host_data(host_data),
        .dbg_reg(dbg_reg), .dbg_idx(dbg_idx), .dbg_data(dbg_data)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(int r, int i, int seed);
        logic [63:0] x;
        x = 64'h9E37_79B9_7F4A_7C15 * 64'(r * 64 + i + seed * 977 + 1);
        return x ^ (x >> 29);
    endfunction

    task automatic host_write(input int r, input int i, input logic [63:0] d);
        host_we = 1'b1; host_reg = 3'(r); host_idx = 6'(i); host_data = d;
        @(negedge clk);
        host_we = 1'b0;
        if (cmd_ready) model[r][i] = d;
    endtask

    task automatic fill_reg(input int r, input int seed);
        for (int i = 0; i < NE; i++) host_write(r, i, pat(r, i, seed));
    endtask

    task automatic check_all(input string req);
        for (int r = 0; r < NR; r++) begin
            for (int i = 0; i < NE; i++) begin
                dbg_reg = 3'(r); dbg_idx = 6'(i);
                #0.1;
                check(dbg_data === model[r][i], req, dbg_data, model[r][i]);
            end
        end
    endtask

    // caller is at a negedge with cmd_ready high; returns at the negedge where done is seen
    task automatic run_cmd(input int op, input int d, input int a, input int b,
                           input logic [63:0] s, input string req);
        logic [63:0] va [NE];
        logic [63:0] vb [NE];
        int n;
        check(cmd_ready === 1'b1, {req, " ready before issue"}, 64'(cmd_ready), 64'd1);
        for (int i = 0; i < NE; i++) begin va[i] = model[a][i]; vb[i] = model[b][i]; end
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_dst = 3'(d);
        cmd_srca = 3'(a); cmd_srcb = 3'(b); cmd_scalar = s;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 1;
        while (done !== 1'b1 && n < 200) begin
            check(cmd_ready === 1'b0, "R6 ready low while busy", 64'(cmd_ready), 64'd0);
            @(negedge clk);
            n++;
        end
        check(n == EXP_TURN, "R7 done timing", 64'(n), 64'(EXP_TURN));
        check(cmd_ready === 1'b1, "R7 ready with done", 64'(cmd_ready), 64'd1);
        for (int i = 0; i < NE; i++) begin
            case (op)
                0: model[d][i] = va[i] + vb[i];
                1: model[d][i] = s + vb[i];
                2: model[d][i] = va[i] * vb[i];
                default: model[d][i] = s * vb[i];
            endcase
        end
    endtask

    task automatic settle_done;
        @(negedge clk);
        check(done === 1'b0, "R7 done one cycle", 64'(done), 64'd0);
    endtask

    task automatic t_reset;
        check(cmd_ready === 1'b1, "R1 ready after reset", 64'(cmd_ready), 64'd1);
        check(done === 1'b0, "R1 done after reset", 64'(done), 64'd0);
    endtask

    task automatic t_debug_read;
        host_write(6, 10, 64'hDEAD_BEEF_0123_4567);
        host_write(6, 11, 64'h0F0F_0F0F_F0F0_F0F0);
        dbg_reg = 3'd6; dbg_idx = 6'd10; #0.1;
        check(dbg_data === 64'hDEAD_BEEF_0123_4567, "R10 debug read", dbg_data, 64'hDEAD_BEEF_0123_4567);
        dbg_idx = 6'd11; #0.1;
        check(dbg_data === 64'h0F0F_0F0F_F0F0_F0F0, "R10 debug read addr change", dbg_data, 64'h0F0F_0F0F_F0F0_F0F0);
        check_all("R9 host write");
    endtask

    task automatic t_add_vv;
        host_write(1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        host_write(2, 0, 64'h0000_0000_0000_0003);
        run_cmd(0, 3, 1, 2, 64'h0, "R2 add vv");
        settle_done();
        check_all("R2 R5 add vv");
        dbg_reg = 3'd3; dbg_idx = 6'd0; #0.1;
        check(dbg_data === 64'd2, "R2 add wraps", dbg_data, 64'd2);
    endtask

    task automatic t_add_sv;
        run_cmd(1, 4, 5, 2, 64'h8000_0000_0000_0001, "R4 add sv");
        settle_done();
        check_all("R4 R5 add sv ignores va");
    endtask

    task automatic t_mul_vv;
        host_write(1, 5, 64'hFFFF_FFFF_FFFF_FFFF);
        host_write(2, 5, 64'hFFFF_FFFF_FFFF_FFFF);
        run_cmd(2, 5, 1, 2, 64'h0, "R3 mul vv");
        settle_done();
        check_all("R3 R5 mul vv");
        dbg_reg = 3'd5; dbg_idx = 6'd5; #0.1;
        check(dbg_data === 64'd1, "R3 low product bits", dbg_data, 64'd1);
    endtask

    task automatic t_mul_sv;
        run_cmd(3, 7, 0, 1, 64'h1234_5678_9ABC_DEF1, "R3 mul sv");
        settle_done();
        check_all("R3 R4 mul sv");
    endtask

    task automatic t_alias;
        run_cmd(0, 2, 2, 2, 64'h0, "R8 vd=va=vb add");
        settle_done();
        check_all("R8 alias add");
        run_cmd(2, 1, 3, 1, 64'h0, "R8 vd=vb mul");
        settle_done();
        check_all("R8 alias mul");
        run_cmd(1, 6, 0, 6, 64'h7, "R8 vd=vb scalar");
        settle_done();
        check_all("R8 alias scalar");
    endtask

    task automatic t_busy;
        int extra;
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_dst = 3'd0;
        cmd_srca = 3'd1; cmd_srcb = 3'd2; cmd_scalar = 64'h0;
        for (int i = 0; i < NE; i++) model[0][i] = model[1][i] + model[2][i];
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (4) @(negedge clk);
        // offered while busy: both must be dropped
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_dst = 3'd4; cmd_scalar = 64'h55;
        host_we = 1'b1; host_reg = 3'd5; host_idx = 6'd7; host_data = 64'hABAB;
        @(negedge clk);
        cmd_valid = 1'b0; host_we = 1'b0;
        extra = 0;
        while (done !== 1'b1 && extra < 200) begin @(negedge clk); extra++; end
        check(extra < 200, "R6 first command completes", 64'(extra), 64'd0);
        extra = 0;
        for (int k = 0; k < 90; k++) begin
            @(negedge clk);
            if (done === 1'b1) extra++;
        end
        check(extra == 0, "R6 busy command ignored", 64'(extra), 64'd0);
        check_all("R6 R9 busy writes ignored");
    endtask

    task automatic t_back_to_back;
        run_cmd(0, 3, 4, 5, 64'h0, "R11 first");
        run_cmd(2, 4, 3, 3, 64'h0, "R11 second in done cycle");
        settle_done();
        check_all("R11 back to back");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_dst = '0; cmd_srca = '0;
        cmd_srcb = '0; cmd_scalar = '0; host_we = 1'b0; host_reg = '0; host_idx = '0;
        host_data = '0; dbg_reg = '0; dbg_idx = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        for (int r = 0; r < NR; r++) fill_reg(r, r + 3);
        t_debug_read();
        t_add_vv();
        t_add_sv();
        t_mul_vv();
        t_mul_sv();
        t_alias();
        t_busy();
        t_back_to_back();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule